// File: doc/BRIEF.md
# I2C Clock Phase Generator

This block produces the SCL waveform for an I2C master from a fast system clock. Software or a sequencer loads one 32-bit divisor word. The upper half sets how long SCL stays released (high), and the lower half sets how long SCL is driven low. Each half counts in units of eight input clocks. The two halves are independent, so duty cycle and rate can both be tuned with no shared prescaler.

Alongside SCL the block emits timing strobes for the byte engine that sits beside it. One strobe marks the middle of each low phase, where SDA may change. Another marks the middle of each high phase, where SDA is sampled; START and STOP edges (SDA moving while SCL is high) are placed on that same point. For a repeated START, the engine releases SDA on the low-phase strobe and pulls it low on the next high-phase strobe. A third strobe marks the first cycle of every low phase.

The high phase counts only while the synchronised SCL line reads high, so a slave that holds SCL low stretches the phase. A newly written divisor is held pending and becomes active at the next low-phase start, so a period already under way is never reshaped. The `scl_i` input must already be synchronised to `clk_i`.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted, and whenever the block is idle, `scl_o` is 1 (released) and no strobe fires. Out of reset the block stays idle until `en_i` is 1.
- R2: The divisor word carries the low-phase field in bits [15:0]. Each low phase lasts 8 × that field input clocks.
- R3: The high-phase field sits in bits [31:16]. When the line is not held low by another device, each high phase lasts 8 × that field input clocks.
- R4: A field value of 0 behaves exactly like a value of 1, giving a phase of 8 clocks.
- R5: `sda_chg_o` pulses for exactly one cycle per low phase, at 0-based cycle index 4 × max(low field, 1) counted from the first low cycle.
- R6: `sda_smp_o` pulses exactly once per high phase. It fires on the cycle where the count of line-high cycles reaches 4 × max(high field, 1) (0-based), which is cycle index stretch + 4 × max(high field, 1) from the first high cycle.
- R7: The high-phase count advances only in cycles where `scl_i` is 1. Each cycle of the high phase with `scl_i` at 0 lengthens that phase by one clock.
- R8: A divisor written with `div_we_i` becomes active only at the next transition into a low phase. A write made during a low phase leaves that period's low and high lengths unchanged, and a write made during a high phase governs the low phase that follows.
- R9: With the block idle and `en_i` at 1, `scl_o` goes low one clock later. When `en_i` is 0 at the end of a high phase, the block returns to idle with SCL released, and the period in progress is completed in full.
- R10: The reset divisor has both fields equal to ceil(ceil(CLK_HZ / (8 × SCL_HZ)) / 2). With the defaults of 125 MHz and 100 kHz this is 79, which gives 632-clock phases.
- R11: `low_start_o` is 1 in the first cycle of every low phase and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; sampled at idle and at each high-phase end |
| div_we_i | input | 1 | Write strobe for the pending divisor |
| div_wdata_i | input | 32 | Divisor word: [31:16] high field, [15:0] low field |
| scl_i | input | 1 | Synchronised SCL line level |
| scl_o | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sda_chg_o | output | 1 | Mid-low strobe: SDA may change |
| sda_smp_o | output | 1 | Mid-high strobe: sample SDA, place START/STOP edges |
| low_start_o | output | 1 | First cycle of a low phase |

## Verification
The hardest situation to reach is a slave stretching the clock in combination with the timing of the sample strobe. The bench feeds `scl_o` back to `scl_i` through a hold gate. The hold gate forces the line low for a chosen number of cycles at the start of each high phase. The stretch amount varies from one divisor setting to the next across a sweep of every high/low field pair from 0 to 5. Divisor writes are placed deliberately in a low phase and in a high phase, which shows which period each write reaches.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // per-half field giving a rate at or below the target SCL frequency
  function automatic int unsigned rst_field(input int unsigned clk_hz,
                                            input int unsigned scl_hz);
    int unsigned d;
    d = (clk_hz + 8 * scl_hz - 1) / (8 * scl_hz);
    return (d + 1) / 2;
  endfunction

endpackage

// File: rtl/scl_tg_divreg.sv
module scl_tg_divreg #(
  parameter int unsigned FIELD_W   = 16,
  parameter int unsigned SCALE_LG  = 3,
  parameter int unsigned RST_FIELD = 79,
  localparam int unsigned CW       = FIELD_W + SCALE_LG,
  localparam int unsigned DW       = 2 * FIELD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          load_i,
  output logic [CW-1:0] hi_len_o,
  output logic [CW-1:0] lo_len_o
);

  localparam logic [FIELD_W-1:0] RF = FIELD_W'(RST_FIELD);

  logic [DW-1:0] pend_q;
  logic [DW-1:0] act_q;
  logic [CW-1:0] len [2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= {RF, RF};
      act_q  <= {RF, RF};
    end else begin
      if (we_i)   pend_q <= wdata_i;
      if (load_i) act_q  <= pend_q;
    end
  end

  // half 0 = low field, half 1 = high field; zero field acts as one
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [FIELD_W-1:0] fld;
    logic [FIELD_W-1:0] fld_fix;
    assign fld     = act_q[h*FIELD_W +: FIELD_W];
    assign fld_fix = (fld == '0) ? FIELD_W'(1) : fld;
    assign len[h]  = {fld_fix, {SCALE_LG{1'b0}}};
  end

  assign lo_len_o = len[0];
  assign hi_len_o = len[1];

endmodule

// File: rtl/scl_tg_fsm.sv
module scl_tg_fsm
  import scl_tg_pkg::*;
#(
  parameter int unsigned CW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          scl_i,
  input  logic [CW-1:0] hi_len_i,
  input  logic [CW-1:0] lo_len_i,
  output phase_e        phase_o,
  output logic [CW-1:0] cnt_o,
  output logic          load_o
);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    load_o = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (en_i) begin
          ph_d   = PH_LOW;
          cnt_d  = '0;
          load_o = 1'b1;
        end
      end
      PH_LOW: begin
        if (cnt_q == lo_len_i - CW'(1)) begin
          ph_d  = PH_HIGH;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_HIGH: begin
        if (scl_i) begin
          if (cnt_q == hi_len_i - CW'(1)) begin
            cnt_d = '0;
            if (en_i) begin
              ph_d   = PH_LOW;
              load_o = 1'b1;
            end else begin
              ph_d = PH_IDLE;
            end
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase_o = ph_q;
  assign cnt_o   = cnt_q;

  // R7
  stretch_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_HIGH && !scl_i) |=> (ph_q == PH_HIGH && $stable(cnt_q)));

  // R2
  low_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_LOW) |-> (cnt_q < lo_len_i));

endmodule

// File: rtl/scl_tg_strobe.sv
module scl_tg_strobe
  import scl_tg_pkg::*;
#(
  parameter int unsigned CW = 19
) (
  input  phase_e        phase_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          scl_i,
  input  logic [CW-1:0] hi_len_i,
  input  logic [CW-1:0] lo_len_i,
  output logic          scl_o,
  output logic          sda_chg_o,
  output logic          sda_smp_o,
  output logic          low_start_o
);

  logic in_low, in_high;

  assign in_low      = (phase_i == PH_LOW);
  assign in_high     = (phase_i == PH_HIGH);
  assign scl_o       = !in_low;
  assign low_start_o = in_low && (cnt_i == '0);
  assign sda_chg_o   = in_low && (cnt_i == (lo_len_i >> 1));
  assign sda_smp_o   = in_high && scl_i && (cnt_i == (hi_len_i >> 1));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tg_pkg::*;
#(
  parameter int unsigned FIELD_W  = 16,
  parameter int unsigned SCALE_LG = 3,
  parameter int unsigned CLK_HZ   = 125_000_000,
  parameter int unsigned SCL_HZ   = 100_000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 div_we_i,
  input  logic [2*FIELD_W-1:0] div_wdata_i,
  input  logic                 scl_i,
  output logic                 scl_o,
  output logic                 sda_chg_o,
  output logic                 sda_smp_o,
  output logic                 low_start_o
);

  localparam int unsigned CW        = FIELD_W + SCALE_LG;
  localparam int unsigned RST_FIELD = rst_field(CLK_HZ, SCL_HZ);

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] hi_len, lo_len;
  logic          load;

  scl_tg_divreg #(
    .FIELD_W  (FIELD_W),
    .SCALE_LG (SCALE_LG),
    .RST_FIELD(RST_FIELD)
  ) i_divreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (div_we_i),
    .wdata_i (div_wdata_i),
    .load_i  (load),
    .hi_len_o(hi_len),
    .lo_len_o(lo_len)
  );

  scl_tg_fsm #(.CW(CW)) i_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .scl_i   (scl_i),
    .hi_len_i(hi_len),
    .lo_len_i(lo_len),
    .phase_o (phase),
    .cnt_o   (cnt),
    .load_o  (load)
  );

  scl_tg_strobe #(.CW(CW)) i_strobe (
    .phase_i    (phase),
    .cnt_i      (cnt),
    .scl_i      (scl_i),
    .hi_len_i   (hi_len),
    .lo_len_i   (lo_len),
    .scl_o      (scl_o),
    .sda_chg_o  (sda_chg_o),
    .sda_smp_o  (sda_smp_o),
    .low_start_o(low_start_o)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_IDLE) |-> (scl_o && !sda_chg_o && !sda_smp_o && !low_start_o));

  // R9
  en_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_IDLE && en_i) |=> (!scl_o && low_start_o));

  // R8
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_IDLE && !load) |=> ($stable(hi_len) && $stable(lo_len)));

  // R5
  chg_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_chg_o |=> !sda_chg_o);

  // R6
  smp_in_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_smp_o |-> (scl_o && scl_i));

endmodule

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        hold = 1'b0;
  logic        scl_o, scl_i, sda_chg, sda_smp, low_start;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  assign scl_i = scl_o & ~hold;

  scl_timing_gen i_scl_timing_gen (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .div_we_i   (we),
    .div_wdata_i(wdata),
    .scl_i      (scl_i),
    .scl_o      (scl_o),
    .sda_chg_o  (sda_chg),
    .sda_smp_o  (sda_smp),
    .low_start_o(low_start)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_div(input int h, input int l);
    we    = 1'b1;
    wdata = {h[15:0], l[15:0]};
    @(negedge clk);
    we    = 1'b0;
  endtask

  // Skips to the next low-phase start, then measures one full period.
  task automatic measure(input int stretch, output int lo_w, output int hi_w,
                         output int chg_at, output int chg_n, output int smp_at,
                         output int smp_n, output int ls_bad);
    lo_w = 0; hi_w = 0; chg_at = -1; chg_n = 0; smp_at = -1; smp_n = 0; ls_bad = 0;
    while (scl_o == 1'b0) @(negedge clk);
    while (scl_o == 1'b1) @(negedge clk);
    while (scl_o == 1'b0) begin
      if (sda_chg) begin chg_at = lo_w; chg_n++; end
      if (low_start != (lo_w == 0)) ls_bad++;
      lo_w++;
      @(negedge clk);
    end
    while (scl_o == 1'b1) begin
      hold = (hi_w < stretch);
      #1;
      if (sda_smp) begin smp_at = hi_w; smp_n++; end
      if (low_start) ls_bad++;
      hi_w++;
      @(negedge clk);
    end
    hold = 1'b0;
  endtask

  initial begin
    int lw, hw, ca, cn, sa, sn, lb;
    // reset state
    repeat (3) @(negedge clk);
    chk(scl_o == 1'b1, "R1", "scl in reset", int'(scl_o), 1);
    chk(!sda_chg && !sda_smp && !low_start, "R1", "strobes in reset",
        int'(sda_chg | sda_smp | low_start), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(scl_o == 1'b1, "R1", "scl idle without enable", int'(scl_o), 1);

    // enable launches low next cycle
    en = 1'b1;
    @(negedge clk);
    chk(scl_o == 1'b0, "R9", "scl after enable", int'(scl_o), 0);
    chk(low_start == 1'b1, "R11", "low_start after enable", int'(low_start), 1);

    // reset divisor 79/79
    measure(0, lw, hw, ca, cn, sa, sn, lb);
    chk(lw == 632, "R10", "default low width", lw, 632);
    chk(hw == 632, "R10", "default high width", hw, 632);

    // sweep all field pairs 0..5 with varied stretch
    for (int h = 0; h < 6; h++) begin
      for (int l = 0; l < 6; l++) begin
        int st, eh, el;
        st = (h + 2 * l) % 4;
        eh = 8 * ((h == 0) ? 1 : h);
        el = 8 * ((l == 0) ? 1 : l);
        wr_div(h, l);
        measure(st, lw, hw, ca, cn, sa, sn, lb);
        chk(lw == el, (l == 0) ? "R4" : "R2", "low width", lw, el);
        chk(hw == eh + st, (h == 0) ? "R4" : ((st != 0) ? "R7" : "R3"),
            "high width", hw, eh + st);
        chk(cn == 1 && ca == el / 2, "R5", "chg position", ca, el / 2);
        chk(sn == 1 && sa == st + eh / 2, "R6", "smp position", sa, st + eh / 2);
        chk(lb == 0, "R11", "low_start misplacement count", lb, 0);
      end
    end

    // R8: write during low keeps this period; now at first low cycle of a 5/5 period
    wr_div(1, 1);
    while (scl_o == 1'b0) @(negedge clk);
    hw = 0;
    while (scl_o == 1'b1) begin hw++; @(negedge clk); end
    chk(hw == 40, "R8", "high width after write in low", hw, 40);
    lw = 0;
    while (scl_o == 1'b0) begin lw++; @(negedge clk); end
    chk(lw == 8, "R8", "next low uses new divisor", lw, 8);
    // R8: write during high governs the following low
    wr_div(3, 6);
    while (scl_o == 1'b1) @(negedge clk);
    lw = 0;
    while (scl_o == 1'b0) begin lw++; @(negedge clk); end
    chk(lw == 48, "R8", "low after write in high", lw, 48);

    // R9: disable mid-period finishes period then idles high
    while (scl_o == 1'b1) @(negedge clk);
    en = 1'b0;
    while (scl_o == 1'b0) @(negedge clk);
    hw = 0;
    while (scl_o == 1'b1 && hw < 200) begin hw++; @(negedge clk); end
    chk(hw == 200, "R9", "scl stays released after disable", hw, 200);
    begin
      int q;
      q = 0;
      repeat (50) begin
        if (!scl_o || sda_chg || sda_smp || low_start) q++;
        @(negedge clk);
      end
      chk(q == 0, "R1", "idle activity count", q, 0);
    end
    en = 1'b1;
    @(negedge clk);
    chk(scl_o == 1'b0, "R9", "relaunch after enable", int'(scl_o), 0);
    measure(0, lw, hw, ca, cn, sa, sn, lb);
    chk(lw == 48 && hw == 24, "R9", "period after relaunch", lw * 1000 + hw, 48024);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule